// File: doc/BRIEF.md
# DMA descriptor chain controller

This block runs the chaining side of one DMA channel. It holds the chain pointer, which is the physical address of the next command descriptor. It also holds two status bits: chain-enable and transfer-active. When the data mover reports that a transfer has finished and chaining is enabled, a small sequencer reads the next descriptor from memory one 64-bit word at a time. It then presents the descriptor's settings words to the channel, along with a one-cycle load strobe.

A CPU write to the chain register also changes the status bits. A nonzero pointer arms the chain and marks the channel active. A zero pointer only disarms the chain. Word 0 of every descriptor carries the pointer to the following descriptor. A zero pointer in that word ends the chain: the register keeps the address of the last descriptor that was fetched, and chain-enable drops. The channel then stops at the next transfer-done. CPU writes are stalled while a fetch is in flight.

Top module: `dchain_ctrl`

## Requirements
- R1: The chain register stores only bits 35:3 of a written value. The read port returns that field at bits 35:3, with bits 63:36 and 2:0 reading zero.
- R2: An accepted CPU write whose bits 35:3 are nonzero stores the address and sets both chain-enable and transfer-active on the next cycle.
- R3: An accepted CPU write whose bits 35:3 are zero stores zero and clears chain-enable. Transfer-active keeps its previous value.
- R4: A transfer-done pulse while chain-enable is set starts a fetch of DESC_WORDS reads. The reads go to the chain address, then +8, +16, and so on, wrapping at 36 bits. Each request and address is held until a read-valid is seen.
- R5: In the cycle after the last word is accepted, ch_load is high for exactly one cycle. At the same time, ch_settings carries descriptor word k (k ≥ 1) at bits (k-1)*64 upward.
- R6: One cycle after ch_load, a nonzero pointer in word 0 bits 35:3 becomes the chain address, and chain-enable and transfer-active stay set. A zero pointer leaves the register at the fetched descriptor's address and clears chain-enable, while transfer-active stays set.
- R7: A transfer-done pulse while chain-enable is clear clears transfer-active and issues no read.
- R8: cpu_stall is high from the cycle after the fetch starts through the ch_load cycle. A CPU write made while it is high has no effect.
- R9: After reset, chain-enable, transfer-active, mem_rd_req, cpu_stall and ch_load are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_wr_en | input | 1 | CPU write strobe for the chain register |
| cpu_wr_data | input | 64 | CPU write value |
| cpu_stall | output | 1 | High while writes are held off |
| cpu_rd_data | output | 64 | Chain register read value |
| chain_en | output | 1 | Chain-enable status |
| xfer_active | output | 1 | Transfer-active status |
| xfer_done | input | 1 | Current transfer finished (one-cycle pulse) |
| mem_rd_req | output | 1 | Descriptor read request |
| mem_rd_addr | output | 36 | Descriptor read byte address |
| mem_rd_valid | input | 1 | Read data valid; completes the pending read |
| mem_rd_data | input | 64 | Read data |
| ch_load | output | 1 | One-cycle strobe: new settings loaded |
| ch_settings | output | 192 | Descriptor words 1..DESC_WORDS-1 |

## Verification
The bench sweeps chain lengths of one to three descriptors against read latencies of zero to three cycles. Each descriptor's contents are computed from its own address. A length of one exercises the zero-pointer end, and longer chains exercise pointer advance. The latency sweep separates a held request from one that steps early. Some runs hold a CPU write against the stall, and a descriptor placed at the top of the address space checks the address wrap. Reserved-bit junk in both CPU writes and word 0 shows that only bits 35:3 are ever stored.

// File: rtl/dchain_pkg.sv
package dchain_pkg;
    localparam int WORD_W = 64;

    typedef enum logic [0:0] {
        SQ_IDLE  = 1'b0,
        SQ_FETCH = 1'b1
    } sq_state_e;
endpackage

// File: rtl/dchain_seq.sv
module dchain_seq
    import dchain_pkg::*;
#(
    parameter int ADDR_MSB   = 35,
    parameter int ADDR_LSB   = 3,
    parameter int DESC_WORDS = 4
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               start_i,
    input  logic [ADDR_MSB-ADDR_LSB:0]         base_i,
    output logic                               rd_req_o,
    output logic [ADDR_MSB:0]                  rd_addr_o,
    input  logic                               rd_valid_i,
    input  logic [WORD_W-1:0]                  rd_data_i,
    output logic                               busy_o,
    output logic                               load_o,
    output logic [ADDR_MSB-ADDR_LSB:0]         next_o,
    output logic [(DESC_WORDS-1)*WORD_W-1:0]   settings_o
);
    localparam int FIELD_W = ADDR_MSB - ADDR_LSB + 1;
    localparam int AW      = ADDR_MSB + 1;
    localparam int IDX_W   = (DESC_WORDS > 1) ? $clog2(DESC_WORDS) : 1;
    localparam int LAST    = DESC_WORDS - 1;
    localparam int SET_W   = (DESC_WORDS - 1) * WORD_W;

    typedef struct packed {
        sq_state_e                           state;
        logic [IDX_W-1:0]                    idx;
        logic [FIELD_W-1:0]                  base;
        logic [DESC_WORDS-1:0][WORD_W-1:0]   words;
        logic                                load;
        logic [SET_W-1:0]                    settings;
    } seq_t;

    seq_t q, d;

    always_comb begin
        d      = q;
        d.load = 1'b0;
        case (q.state)
            SQ_IDLE: begin
                if (start_i) begin
                    d.state = SQ_FETCH;
                    d.idx   = '0;
                    d.base  = base_i;
                end
            end
            SQ_FETCH: begin
                if (rd_valid_i) begin
                    d.words[q.idx] = rd_data_i;
                    if (q.idx == IDX_W'(LAST)) begin
                        d.state = SQ_IDLE;
                        d.load  = 1'b1;
                        for (int k = 1; k < DESC_WORDS; k++) begin
                            d.settings[(k-1)*WORD_W +: WORD_W] =
                                (k == LAST) ? rd_data_i : q.words[k];
                        end
                    end else begin
                        d.idx = q.idx + 1'b1;
                    end
                end
            end
            default: d.state = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign rd_req_o   = (q.state == SQ_FETCH);
    assign rd_addr_o  = {q.base + FIELD_W'(q.idx), {ADDR_LSB{1'b0}}};
    assign busy_o     = (q.state == SQ_FETCH) || q.load;
    assign load_o     = q.load;
    assign next_o     = q.words[0][ADDR_MSB:ADDR_LSB];
    assign settings_o = q.settings;

    logic unused_words;
    assign unused_words = ^q.words;

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req_o && !rd_valid_i) |=> (rd_req_o && $stable(rd_addr_o))); // R4

    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req_o && rd_valid_i && q.idx != IDX_W'(LAST)) |=>
            (rd_req_o && rd_addr_o == $past(rd_addr_o) + AW'(1 << ADDR_LSB))); // R4

    AST_LOAD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        load_o |=> !load_o); // R5
endmodule

// File: rtl/dchain_regs.sv
module dchain_regs
    import dchain_pkg::*;
#(
    parameter int ADDR_MSB = 35,
    parameter int ADDR_LSB = 3
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en_i,
    input  logic [WORD_W-1:0]           wr_data_i,
    input  logic                        busy_i,
    input  logic                        xfer_done_i,
    input  logic                        load_i,
    input  logic [ADDR_MSB-ADDR_LSB:0]  next_i,
    output logic                        start_o,
    output logic [ADDR_MSB-ADDR_LSB:0]  chain_o,
    output logic                        chain_en_o,
    output logic                        xfer_active_o,
    output logic [WORD_W-1:0]           rd_data_o
);
    localparam int FIELD_W = ADDR_MSB - ADDR_LSB + 1;

    typedef struct packed {
        logic [FIELD_W-1:0] chain;
        logic               en;
        logic               act;
    } reg_t;

    reg_t q, d;
    logic [FIELD_W-1:0] wr_field;
    logic               wr_ok;

    assign wr_field = wr_data_i[ADDR_MSB:ADDR_LSB];
    assign wr_ok    = wr_en_i && !busy_i;

    always_comb begin
        d       = q;
        start_o = xfer_done_i && !busy_i && q.en;
        if (xfer_done_i && !busy_i && !q.en) d.act = 1'b0;
        if (load_i) begin
            if (next_i != '0) d.chain = next_i;
            else              d.en    = 1'b0;
        end
        if (wr_ok) begin
            d.chain = wr_field;
            if (wr_field != '0) begin
                d.en  = 1'b1;
                d.act = 1'b1;
            end else begin
                d.en  = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign chain_o       = q.chain;
    assign chain_en_o    = q.en;
    assign xfer_active_o = q.act;
    assign rd_data_o     = WORD_W'({q.chain, {ADDR_LSB{1'b0}}});

    logic unused_bits;
    assign unused_bits = ^{wr_data_i[WORD_W-1:ADDR_MSB+1], wr_data_i[ADDR_LSB-1:0]};

    AST_WRITE_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ok && wr_field != '0) |=>
            (chain_en_o && xfer_active_o && chain_o == $past(wr_field))); // R2

    AST_WRITE_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ok && wr_field == '0 && !xfer_done_i) |=>
            (!chain_en_o && xfer_active_o == $past(xfer_active_o))); // R3

    AST_CHAIN_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && next_i != '0) |=> (chain_o == $past(next_i) && chain_en_o)); // R6

    AST_CHAIN_END_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && next_i == '0) |=>
            (chain_o == $past(chain_o) && !chain_en_o && xfer_active_o)); // R6

    AST_IDLE_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_done_i && !busy_i && !chain_en_o && !wr_en_i) |=> !xfer_active_o); // R7

    AST_STALL_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_i && !load_i) |=> $stable(chain_o)); // R8
endmodule

// File: rtl/dchain_ctrl.sv
module dchain_ctrl
    import dchain_pkg::*;
#(
    parameter int ADDR_MSB   = 35,
    parameter int ADDR_LSB   = 3,
    parameter int DESC_WORDS = 4
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              cpu_wr_en,
    input  logic [63:0]                       cpu_wr_data,
    output logic                              cpu_stall,
    output logic [63:0]                       cpu_rd_data,
    output logic                              chain_en,
    output logic                              xfer_active,
    input  logic                              xfer_done,
    output logic                              mem_rd_req,
    output logic [ADDR_MSB:0]                 mem_rd_addr,
    input  logic                              mem_rd_valid,
    input  logic [63:0]                       mem_rd_data,
    output logic                              ch_load,
    output logic [(DESC_WORDS-1)*64-1:0]      ch_settings
);
    localparam int FIELD_W = ADDR_MSB - ADDR_LSB + 1;

    logic               start_w;
    logic               busy_w;
    logic               load_w;
    logic [FIELD_W-1:0] chain_w;
    logic [FIELD_W-1:0] next_w;

    dchain_regs #(
        .ADDR_MSB (ADDR_MSB),
        .ADDR_LSB (ADDR_LSB)
    ) u_regs (
        .clk           (clk),
        .rst_n         (rst_n),
        .wr_en_i       (cpu_wr_en),
        .wr_data_i     (cpu_wr_data),
        .busy_i        (busy_w),
        .xfer_done_i   (xfer_done),
        .load_i        (load_w),
        .next_i        (next_w),
        .start_o       (start_w),
        .chain_o       (chain_w),
        .chain_en_o    (chain_en),
        .xfer_active_o (xfer_active),
        .rd_data_o     (cpu_rd_data)
    );

    dchain_seq #(
        .ADDR_MSB   (ADDR_MSB),
        .ADDR_LSB   (ADDR_LSB),
        .DESC_WORDS (DESC_WORDS)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_w),
        .base_i     (chain_w),
        .rd_req_o   (mem_rd_req),
        .rd_addr_o  (mem_rd_addr),
        .rd_valid_i (mem_rd_valid),
        .rd_data_i  (mem_rd_data),
        .busy_o     (busy_w),
        .load_o     (load_w),
        .next_o     (next_w),
        .settings_o (ch_settings)
    );

    assign cpu_stall = busy_w;
    assign ch_load   = load_w;

    AST_STALL_COVERS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_rd_req) |-> cpu_stall); // R8

    AST_LOAD_ENDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        ch_load |-> !mem_rd_req); // R5
endmodule

// File: tb/test_dchain_ctrl.sv
module test_dchain_ctrl;
    localparam int NW = 4;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               cpu_wr_en = 1'b0;
    logic [63:0]        cpu_wr_data = '0;
    logic               cpu_stall;
    logic [63:0]        cpu_rd_data;
    logic               chain_en;
    logic               xfer_active;
    logic               xfer_done = 1'b0;
    logic               mem_rd_req;
    logic [35:0]        mem_rd_addr;
    logic               mem_rd_valid = 1'b0;
    logic [63:0]        mem_rd_data = '0;
    logic               ch_load;
    logic [(NW-1)*64-1:0] ch_settings;

    int n_chk = 0;
    int n_err = 0;

    logic [35:0] exp_base;
    logic [32:0] cur_next;
    int          rd_k;
    int          mem_lat;
    int          lat_cnt;

    dchain_ctrl i_dchain_ctrl (
        .clk(clk), .rst_n(rst_n), .cpu_wr_en(cpu_wr_en), .cpu_wr_data(cpu_wr_data),
        .cpu_stall(cpu_stall), .cpu_rd_data(cpu_rd_data), .chain_en(chain_en),
        .xfer_active(xfer_active), .xfer_done(xfer_done), .mem_rd_req(mem_rd_req),
        .mem_rd_addr(mem_rd_addr), .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data),
        .ch_load(ch_load), .ch_settings(ch_settings)
    );

    always #2 clk = ~clk;

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] body_word(input logic [35:0] a, input int k);
        return {28'(k * 3 + 1), a} ^ 64'hC3C3_0000_5A5A_1234;
    endfunction

    // memory responder: valid after mem_lat waiting cycles, data computed from address
    always @(negedge clk) begin
        if (mem_rd_req) begin
            if (lat_cnt >= mem_lat) begin
                lat_cnt = 0;
                chk(rd_k < NW, "R4 read count", 64'(rd_k), 64'(NW - 1));
                chk(mem_rd_addr == exp_base + 36'(rd_k * 8), "R4 read address",
                    64'(mem_rd_addr), 64'(exp_base + 36'(rd_k * 8)));
                mem_rd_valid = 1'b1;
                mem_rd_data  = (rd_k == 0) ? {28'hABCDEF1, cur_next, 3'b101}
                                           : body_word(exp_base, rd_k);
                rd_k++;
            end else begin
                lat_cnt++;
                mem_rd_valid = 1'b0;
            end
        end else begin
            lat_cnt      = 0;
            mem_rd_valid = 1'b0;
        end
    end

    task automatic cpu_write(input logic [63:0] v);
        @(negedge clk);
        cpu_wr_en   = 1'b1;
        cpu_wr_data = v;
        @(negedge clk);
        cpu_wr_en   = 1'b0;
    endtask

    task automatic stop_check;
        rd_k = 0;
        @(negedge clk);
        xfer_done = 1'b1;
        @(negedge clk);
        xfer_done = 1'b0;
        chk(xfer_active == 1'b0, "R7 active cleared", 64'(xfer_active), 64'd0);
        chk(mem_rd_req == 1'b0, "R7 no read", 64'(mem_rd_req), 64'd0);
        chk(rd_k == 0, "R7 no read served", 64'(rd_k), 64'd0);
    endtask

    task automatic run_chain(input logic [35:0] a0, input int len, input int lat, input bit poke);
        logic [35:0] daddr [3];
        int wait_n;
        for (int i = 0; i < len; i++) daddr[i] = a0 + 36'(i) * 36'h0_2468_1358;
        mem_lat = lat;
        cpu_write({28'hFEDCBA9, a0[35:3], 3'b111});
        chk(cpu_rd_data == {28'd0, a0}, "R1 readback masked", cpu_rd_data, {28'd0, a0});
        chk(chain_en && xfer_active, "R2 armed", {62'd0, chain_en, xfer_active}, 64'd3);
        for (int i = 0; i < len; i++) begin
            exp_base = daddr[i];
            cur_next = (i < len - 1) ? daddr[i+1][35:3] : 33'd0;
            rd_k = 0;
            @(negedge clk);
            xfer_done = 1'b1;
            @(negedge clk);
            xfer_done = 1'b0;
            chk(cpu_stall == 1'b1, "R8 stall during fetch", 64'(cpu_stall), 64'd1);
            if (poke) begin
                cpu_wr_en   = 1'b1;
                cpu_wr_data = 64'h0000_0005_5555_5550;
            end
            wait_n = 0;
            while (!ch_load && wait_n < 100) begin
                @(negedge clk);
                wait_n++;
            end
            cpu_wr_en = 1'b0;
            chk(ch_load == 1'b1, "R5 load strobe", 64'(ch_load), 64'd1);
            chk(cpu_stall == 1'b1, "R8 stall in load cycle", 64'(cpu_stall), 64'd1);
            chk(rd_k == NW, "R4 all words read", 64'(rd_k), 64'(NW));
            for (int k = 1; k < NW; k++) begin
                chk(ch_settings[(k-1)*64 +: 64] == body_word(daddr[i], k), "R5 settings word",
                    ch_settings[(k-1)*64 +: 64], body_word(daddr[i], k));
            end
            @(negedge clk);
            chk(ch_load == 1'b0, "R5 load one cycle", 64'(ch_load), 64'd0);
            chk(cpu_stall == 1'b0, "R8 stall released", 64'(cpu_stall), 64'd0);
            if (i < len - 1) begin
                chk(cpu_rd_data == {28'd0, daddr[i+1]}, "R6 chain advance", cpu_rd_data, {28'd0, daddr[i+1]});
                chk(chain_en == 1'b1, "R6 chain stays enabled", 64'(chain_en), 64'd1);
            end else begin
                chk(cpu_rd_data == {28'd0, daddr[i]}, "R6 chain end holds", cpu_rd_data, {28'd0, daddr[i]});
                chk(chain_en == 1'b0, "R6 chain disabled", 64'(chain_en), 64'd0);
            end
            chk(xfer_active == 1'b1, "R6 active kept", 64'(xfer_active), 64'd1);
        end
        stop_check();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        exp_base = '0;
        cur_next = '0;
        rd_k     = 0;
        mem_lat  = 0;
        lat_cnt  = 0;
        repeat (3) @(negedge clk);
        chk(!chain_en && !xfer_active, "R9 status after reset", {62'd0, chain_en, xfer_active}, 64'd0);
        chk(!mem_rd_req && !cpu_stall && !ch_load, "R9 outputs after reset",
            {61'd0, mem_rd_req, cpu_stall, ch_load}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reserved bits never stored
        cpu_write(64'hFFFF_FFFF_FFFF_FFFF);
        chk(cpu_rd_data == 64'h0000_000F_FFFF_FFF8, "R1 all-ones write", cpu_rd_data, 64'h0000_000F_FFFF_FFF8);

        // R3: zero field write (reserved bits only) clears enable, keeps active
        cpu_write(64'hFFFF_FFF0_0000_0007);
        chk(chain_en == 1'b0, "R3 enable cleared", 64'(chain_en), 64'd0);
        chk(xfer_active == 1'b1, "R3 active kept", 64'(xfer_active), 64'd1);
        chk(cpu_rd_data == 64'd0, "R3 zero stored", cpu_rd_data, 64'd0);
        stop_check();
        cpu_write(64'h0);
        chk(xfer_active == 1'b0, "R3 active stays clear", 64'(xfer_active), 64'd0);

        // sweep of latency and chain length
        for (int lat = 0; lat < 4; lat++) begin
            for (int len = 1; len <= 3; len++) begin
                run_chain({3'(lat), 30'(len * 12345 + lat * 777 + 1), 3'b000}, len, lat, ((lat + len) % 2) == 1);
            end
        end

        // address wrap at top of space
        run_chain(36'hF_FFFF_FFF8, 2, 1, 1'b1);

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule